// File: doc/BRIEF.md
# Processor interrupt entry sequencer

This block carries a processor from normal execution into an event handler. At an instruction boundary it looks at three request sources: a maskable request, a non-maskable request and an exception request raised by software or by a detected execution fault. Each source carries an 8-bit event number. If one of them is taken, the block saves the interrupted state onto a downward-growing memory stack, one 32-bit word per push. It then reads the handler address from a 256-entry vector table and returns the new code segment, instruction pointer, flags and stack pointer.

All memory traffic goes through one word-wide port with a request/ready handshake, so the block works with memory of any latency. The surrounding core supplies its current register values and privilege levels and holds them stable at the boundary. It takes the results when the one-cycle completion pulse appears.

Top module: `irq_entry_seq`

## Requirements
- R1: A maskable request is taken only while the interrupt-enable flag (cur_flags bit 9) is 1. With bit 9 at 0 and no other request, no memory access occurs and no completion pulse appears.
- R2: A non-maskable request and an exception request are each taken whatever the value of flags bit 9.
- R3: Requests are sampled only on a clock edge where at_boundary is 1 and the block is idle. When several are pending, the exception wins over the non-maskable request, and the non-maskable request wins over the maskable one. Requests seen while busy, or without at_boundary, start nothing.
- R4: The pushes are made in this fixed order. When handler_pl differs from cur_cpl, the stack segment is pushed first, then the stack pointer. After that come the flags, the code segment and the instruction pointer. 16-bit segments are pushed zero-extended to 32 bits.
- R5: Each push writes to the stack pointer minus 4 and then lowers the pointer by 4. On completion, new_sp equals cur_sp minus 4 times the number of pushes.
- R6: An error code is pushed, as the last push, only when the exception request wins and exc_has_err is 1.
- R7: The flags word is pushed unmodified. new_flags equals it with bit 9 (interrupt enable) and bit 8 (trap) cleared and all other bits kept.
- R8: After the pushes, one word is read from vt_base plus 4 times the event number. Its upper 16 bits become new_cs and its lower 16 bits, zero-extended, become new_ip.
- R9: mem_req stays asserted with stable mem_we, mem_addr and mem_wdata until mem_ready is seen. A transfer completes on each edge where mem_req and mem_ready are both 1.
- R10: done is high for exactly one cycle, the cycle after the vector read completes. In that cycle busy is 0 and the new_* outputs hold the results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| at_boundary | input | 1 | Instruction boundary; requests are sampled only here |
| mi_req | input | 1 | Maskable interrupt request |
| mi_vec | input | 8 | Maskable event number |
| nmi_req | input | 1 | Non-maskable interrupt request |
| nmi_vec | input | 8 | Non-maskable event number |
| exc_req | input | 1 | Exception request |
| exc_vec | input | 8 | Exception event number |
| exc_has_err | input | 1 | Exception carries an error code |
| exc_err | input | 32 | Error code word |
| cur_flags | input | 32 | Current flags register |
| cur_cs | input | 16 | Current code segment |
| cur_ip | input | 32 | Current instruction pointer |
| cur_ss | input | 16 | Current stack segment |
| cur_sp | input | 32 | Current stack pointer |
| cur_cpl | input | 2 | Current privilege level |
| handler_pl | input | 2 | Privilege level of the handler |
| vt_base | input | 32 | Byte address of the vector table |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write (push), 0 = read (vector) |
| mem_addr | output | 32 | Byte address of the access |
| mem_wdata | output | 32 | Word to write |
| mem_rdata | input | 32 | Word read |
| mem_ready | input | 1 | Memory accepts or returns the word this cycle |
| busy | output | 1 | Entry sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| new_flags | output | 32 | Flags with bits 9 and 8 cleared |
| new_cs | output | 16 | Handler code segment |
| new_ip | output | 32 | Handler instruction pointer |
| new_sp | output | 32 | Stack pointer after the pushes |

## Verification
The hardest case to reach from the ports is a request that arrives while a sequence is already running, with memory stalling in the middle of it. A late request must neither restart the sequence nor change which vector is read. The bench starts a maskable entry with wait states on memory. It then holds a non-maskable request together with at_boundary for several cycles during the pushes. After that it checks that exactly one completion happened, that the push count is the same, and that the handler address came from the maskable event number. Mixed-request rows in the stimulus table cover the exception-over-NMI and NMI-over-maskable priorities, with and without a privilege change.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SS,
    ST_SP,
    ST_FL,
    ST_CS,
    ST_IP,
    ST_EC,
    ST_VEC
  } step_e;

  // First step after acceptance: stack words only on a privilege change.
  function automatic step_e first_step(input logic pl_chg);
    return pl_chg ? ST_SS : ST_FL;
  endfunction

  // Fixed push order with optional error-code step.
  function automatic step_e next_step(input step_e s, input logic has_err);
    case (s)
      ST_SS:   return ST_SP;
      ST_SP:   return ST_FL;
      ST_FL:   return ST_CS;
      ST_CS:   return ST_IP;
      ST_IP:   return has_err ? ST_EC : ST_VEC;
      ST_EC:   return ST_VEC;
      default: return ST_IDLE;
    endcase
  endfunction

endpackage

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int VW = 8,
  parameter int DW = 32
) (
  input  logic          sample,
  input  logic          if_flag,
  input  logic          mi_req,
  input  logic [VW-1:0] mi_vec,
  input  logic          nmi_req,
  input  logic [VW-1:0] nmi_vec,
  input  logic          exc_req,
  input  logic [VW-1:0] exc_vec,
  input  logic          exc_has_err,
  input  logic [DW-1:0] exc_err,
  output logic          take,
  output logic [VW-1:0] sel_vec,
  output logic          sel_has_err,
  output logic [DW-1:0] sel_err
);

  logic mi_ok;
  assign mi_ok = mi_req && if_flag;

  always_comb begin
    take        = 1'b0;
    sel_vec     = '0;
    sel_has_err = 1'b0;
    sel_err     = '0;
    if (sample) begin
      if (exc_req) begin
        take        = 1'b1;
        sel_vec     = exc_vec;
        sel_has_err = exc_has_err;
        sel_err     = exc_err;
      end else if (nmi_req) begin
        take    = 1'b1;
        sel_vec = nmi_vec;
      end else if (mi_ok) begin
        take    = 1'b1;
        sel_vec = mi_vec;
      end
    end
  end

endmodule

// File: rtl/irq_word_mux.sv
module irq_word_mux
  import irq_entry_pkg::*;
#(
  parameter int AW   = 32,
  parameter int DW   = 32,
  parameter int VW   = 8,
  parameter int SEGW = 16
) (
  input  step_e           step,
  input  logic [AW-1:0]   sp,
  input  logic [AW-1:0]   tbl_base,
  input  logic [VW-1:0]   vec,
  input  logic [SEGW-1:0] ss_w,
  input  logic [AW-1:0]   sp_w,
  input  logic [DW-1:0]   flags_w,
  input  logic [SEGW-1:0] cs_w,
  input  logic [AW-1:0]   ip_w,
  input  logic [DW-1:0]   err_w,
  output logic            req,
  output logic            we,
  output logic [AW-1:0]   addr,
  output logic [DW-1:0]   wdata
);

  localparam int WORD_BYTES = DW / 8;
  localparam int ZW         = DW - SEGW;

  function automatic logic [AW-1:0] push_addr(input logic [AW-1:0] p);
    return p - AW'(WORD_BYTES);
  endfunction

  function automatic logic [AW-1:0] entry_addr(input logic [AW-1:0] b, input logic [VW-1:0] v);
    return b + AW'(v) * AW'(WORD_BYTES);
  endfunction

  always_comb begin
    req   = (step != ST_IDLE);
    we    = (step != ST_IDLE) && (step != ST_VEC);
    addr  = push_addr(sp);
    wdata = '0;
    case (step)
      ST_SS:  wdata = {{ZW{1'b0}}, ss_w};
      ST_SP:  wdata = DW'(sp_w);
      ST_FL:  wdata = flags_w;
      ST_CS:  wdata = {{ZW{1'b0}}, cs_w};
      ST_IP:  wdata = DW'(ip_w);
      ST_EC:  wdata = err_w;
      ST_VEC: addr  = entry_addr(tbl_base, vec);
      default: addr = '0;
    endcase
  end

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_entry_pkg::*;
#(
  parameter int AW     = 32,
  parameter int DW     = 32,
  parameter int VW     = 8,
  parameter int SEGW   = 16,
  parameter int PLW    = 2,
  parameter int IF_BIT = 9,
  parameter int TF_BIT = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            at_boundary,
  input  logic            mi_req,
  input  logic [VW-1:0]   mi_vec,
  input  logic            nmi_req,
  input  logic [VW-1:0]   nmi_vec,
  input  logic            exc_req,
  input  logic [VW-1:0]   exc_vec,
  input  logic            exc_has_err,
  input  logic [DW-1:0]   exc_err,
  input  logic [DW-1:0]   cur_flags,
  input  logic [SEGW-1:0] cur_cs,
  input  logic [AW-1:0]   cur_ip,
  input  logic [SEGW-1:0] cur_ss,
  input  logic [AW-1:0]   cur_sp,
  input  logic [PLW-1:0]  cur_cpl,
  input  logic [PLW-1:0]  handler_pl,
  input  logic [AW-1:0]   vt_base,
  output logic            mem_req,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata,
  input  logic [DW-1:0]   mem_rdata,
  input  logic            mem_ready,
  output logic            busy,
  output logic            done,
  output logic [DW-1:0]   new_flags,
  output logic [SEGW-1:0] new_cs,
  output logic [AW-1:0]   new_ip,
  output logic [AW-1:0]   new_sp
);

  localparam int WORD_BYTES = DW / 8;
  localparam int OFFW       = DW - SEGW;

  function automatic logic [DW-1:0] strip_flags(input logic [DW-1:0] f);
    logic [DW-1:0] r;
    r         = f;
    r[IF_BIT] = 1'b0;
    r[TF_BIT] = 1'b0;
    return r;
  endfunction

  step_e           step_q;
  logic [AW-1:0]   sp_q;
  logic [VW-1:0]   vec_q;
  logic            err_en_q;
  logic [DW-1:0]   err_q;
  logic [DW-1:0]   flags_q;
  logic [SEGW-1:0] cs_q;
  logic [AW-1:0]   ip_q;
  logic [SEGW-1:0] ss_q;
  logic [AW-1:0]   sp0_q;
  logic [AW-1:0]   base_q;
  logic [DW-1:0]   flags_out_q;
  logic [SEGW-1:0] cs_out_q;
  logic [AW-1:0]   ip_out_q;
  logic            done_q;

  // Named internal events for assertions.
  logic            idle;
  logic            sample;
  logic            take;
  logic            fire;
  logic            push_fire;
  logic            vec_fire;
  logic            pl_chg;
  logic [VW-1:0]   sel_vec;
  logic            sel_has_err;
  logic [DW-1:0]   sel_err;

  assign idle      = (step_q == ST_IDLE);
  assign sample    = idle && at_boundary;
  assign pl_chg    = (handler_pl != cur_cpl);
  assign fire      = mem_req && mem_ready;
  assign push_fire = fire && mem_we;
  assign vec_fire  = fire && !mem_we;

  irq_arbiter #(.VW(VW), .DW(DW)) arb_i (
    .sample      (sample),
    .if_flag     (cur_flags[IF_BIT]),
    .mi_req      (mi_req),
    .mi_vec      (mi_vec),
    .nmi_req     (nmi_req),
    .nmi_vec     (nmi_vec),
    .exc_req     (exc_req),
    .exc_vec     (exc_vec),
    .exc_has_err (exc_has_err),
    .exc_err     (exc_err),
    .take        (take),
    .sel_vec     (sel_vec),
    .sel_has_err (sel_has_err),
    .sel_err     (sel_err)
  );

  irq_word_mux #(.AW(AW), .DW(DW), .VW(VW), .SEGW(SEGW)) mux_i (
    .step     (step_q),
    .sp       (sp_q),
    .tbl_base (base_q),
    .vec      (vec_q),
    .ss_w     (ss_q),
    .sp_w     (sp0_q),
    .flags_w  (flags_q),
    .cs_w     (cs_q),
    .ip_w     (ip_q),
    .err_w    (err_q),
    .req      (mem_req),
    .we       (mem_we),
    .addr     (mem_addr),
    .wdata    (mem_wdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step_q      <= ST_IDLE;
      sp_q        <= '0;
      vec_q       <= '0;
      err_en_q    <= 1'b0;
      err_q       <= '0;
      flags_q     <= '0;
      cs_q        <= '0;
      ip_q        <= '0;
      ss_q        <= '0;
      sp0_q       <= '0;
      base_q      <= '0;
      flags_out_q <= '0;
      cs_out_q    <= '0;
      ip_out_q    <= '0;
      done_q      <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (idle) begin
        if (take) begin
          step_q   <= first_step(pl_chg);
          sp_q     <= cur_sp;
          sp0_q    <= cur_sp;
          vec_q    <= sel_vec;
          err_en_q <= sel_has_err;
          err_q    <= sel_err;
          flags_q  <= cur_flags;
          cs_q     <= cur_cs;
          ip_q     <= cur_ip;
          ss_q     <= cur_ss;
          base_q   <= vt_base;
        end
      end else if (push_fire) begin
        sp_q   <= sp_q - AW'(WORD_BYTES);
        step_q <= next_step(step_q, err_en_q);
        if (step_q == ST_FL) flags_out_q <= strip_flags(flags_q);
      end else if (vec_fire) begin
        cs_out_q <= mem_rdata[DW-1 -: SEGW];
        ip_out_q <= AW'(mem_rdata[OFFW-1:0]);
        step_q   <= ST_IDLE;
        done_q   <= 1'b1;
      end
    end
  end

  assign busy      = !idle;
  assign done      = done_q;
  assign new_flags = flags_out_q;
  assign new_cs    = cs_out_q;
  assign new_ip    = ip_out_q;
  assign new_sp    = sp_q;

  // R1: maskable request with interrupt enable clear starts nothing.
  p_mask_block_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && at_boundary && mi_req && !cur_flags[IF_BIT] && !nmi_req && !exc_req) |=> !busy);

  // R2: non-maskable request at a boundary is always taken.
  p_nmi_taken_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && at_boundary && nmi_req) |=> busy);

  // R3: nothing starts without a boundary.
  p_no_boundary_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !at_boundary) |=> !busy);

  // R5: each completed push lowers the stack pointer by one word.
  p_sp_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    push_fire |=> (new_sp == $past(new_sp) - AW'(WORD_BYTES)));

  // R7: interrupt-enable and trap flags are clear at completion.
  p_flags_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!new_flags[IF_BIT] && !new_flags[TF_BIT]));

  // R9: a stalled request holds its address, data and direction.
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_wdata) && $stable(mem_we)));

  // R10: done is a single-cycle pulse seen while idle.
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

endmodule

// File: tb/irq_entry_seq_tb_top.sv
module irq_entry_seq_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        at_boundary = 1'b0;
  logic        mi_req = 1'b0, nmi_req = 1'b0, exc_req = 1'b0, exc_has_err = 1'b0;
  logic [7:0]  mi_vec = '0, nmi_vec = '0, exc_vec = '0;
  logic [31:0] exc_err = '0, cur_flags = '0, cur_ip = '0, cur_sp = '0, vt_base = 32'h0001_0000;
  logic [15:0] cur_cs = '0, cur_ss = '0;
  logic [1:0]  cur_cpl = 2'd3, handler_pl = 2'd3;
  logic        mem_req, mem_we, mem_ready, busy, done;
  logic [31:0] mem_addr, mem_wdata, mem_rdata, new_flags, new_ip, new_sp;
  logic [15:0] new_cs;

  int checks = 0, errors = 0;
  int wait_cfg = 0, wcnt = 0;
  logic [31:0] log_a [256];
  logic [31:0] log_d [256];
  int ln = 0, dcnt = 0;

  always #5 clk = ~clk;

  function automatic logic [31:0] vword(input logic [31:0] a);
    return {a[15:0] ^ 16'h5A00, a[15:0] + 16'h1234};
  endfunction

  assign mem_rdata = vword(mem_addr);
  assign mem_ready = mem_req && (wcnt == 0);

  always @(posedge clk) begin
    if (mem_req && mem_ready) begin
      wcnt <= wait_cfg;
      if (mem_we) begin
        log_a[ln % 256] <= mem_addr;
        log_d[ln % 256] <= mem_wdata;
        ln <= ln + 1;
      end
    end else if (mem_req && wcnt > 0) wcnt <= wcnt - 1;
    if (done) dcnt <= dcnt + 1;
  end

  irq_entry_seq dut_i (
    .clk(clk), .rst_n(rst_n), .at_boundary(at_boundary),
    .mi_req(mi_req), .mi_vec(mi_vec), .nmi_req(nmi_req), .nmi_vec(nmi_vec),
    .exc_req(exc_req), .exc_vec(exc_vec), .exc_has_err(exc_has_err), .exc_err(exc_err),
    .cur_flags(cur_flags), .cur_cs(cur_cs), .cur_ip(cur_ip), .cur_ss(cur_ss), .cur_sp(cur_sp),
    .cur_cpl(cur_cpl), .handler_pl(handler_pl), .vt_base(vt_base),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ready(mem_ready),
    .busy(busy), .done(done), .new_flags(new_flags), .new_cs(new_cs), .new_ip(new_ip), .new_sp(new_sp)
  );

  task automatic chk(input logic ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // kind[14:12] 0 mi,1 nmi,2 exc,3 all three,4 mi+nmi; vec[11:4]; has_err[3]; plchg[2]; if_set[1]; slow[0]
  localparam logic [14:0] TBL [10] = '{
    {3'd0, 8'h20, 1'b0, 1'b0, 1'b1, 1'b0},
    {3'd0, 8'h21, 1'b0, 1'b0, 1'b0, 1'b0},
    {3'd1, 8'h02, 1'b0, 1'b1, 1'b0, 1'b1},
    {3'd2, 8'h0D, 1'b1, 1'b1, 1'b0, 1'b1},
    {3'd2, 8'h03, 1'b0, 1'b0, 1'b1, 1'b0},
    {3'd3, 8'h0E, 1'b1, 1'b0, 1'b1, 1'b1},
    {3'd4, 8'h02, 1'b0, 1'b1, 1'b1, 1'b0},
    {3'd2, 8'hFF, 1'b1, 1'b0, 1'b0, 1'b0},
    {3'd0, 8'h00, 1'b0, 1'b1, 1'b1, 1'b1},
    {3'd1, 8'h80, 1'b1, 1'b0, 1'b0, 1'b0}
  };

  task automatic wait_done(output logic seen);
    seen = 1'b0;
    for (int c = 0; c < 200 && !seen; c++) begin
      @(negedge clk);
      if (done) seen = 1'b1;
    end
  endtask

  task automatic run_row(input int idx, input logic [14:0] row);
    logic [2:0]  kind;
    logic [7:0]  v;
    logic        he, pc, ifs, taken, errp, seen;
    logic [31:0] exp_w [8];
    logic [31:0] sp0, fl, ea;
    int          n, ln0, d0;
    kind = row[14:12]; v = row[11:4]; he = row[3]; pc = row[2]; ifs = row[1];
    sp0 = 32'h0000_8000 - 32'(idx) * 32'h100;
    fl  = 32'h0000_0146 | (ifs ? 32'h200 : 32'h0);
    @(negedge clk);
    wait_cfg = row[0] ? 2 : 0; wcnt = wait_cfg;
    cur_flags = fl; cur_cs = 16'h1111 + 16'(idx); cur_ip = 32'h0000_2222 + 32'(idx);
    cur_ss = 16'h3333; cur_sp = sp0; cur_cpl = 2'd3; handler_pl = pc ? 2'd0 : 2'd3;
    exc_err = 32'hE000_0000 | 32'(idx); exc_has_err = he;
    mi_req = (kind == 0 || kind == 3 || kind == 4);
    nmi_req = (kind == 1 || kind == 3 || kind == 4);
    exc_req = (kind == 2 || kind == 3);
    mi_vec = (kind == 0) ? v : v ^ 8'h11;
    nmi_vec = (kind == 1 || kind == 4) ? v : v ^ 8'h22;
    exc_vec = v;
    taken = !(kind == 0 && !ifs);
    errp  = (kind == 2 || kind == 3) && he;
    n = 0;
    if (pc) begin exp_w[n] = {16'h0, cur_ss}; n++; exp_w[n] = sp0; n++; end
    exp_w[n] = fl; n++;
    exp_w[n] = {16'h0, cur_cs}; n++;
    exp_w[n] = cur_ip; n++;
    if (errp) begin exp_w[n] = exc_err; n++; end
    ln0 = ln; d0 = dcnt;
    at_boundary = 1'b1;
    @(negedge clk);
    at_boundary = 1'b0; mi_req = 0; nmi_req = 0; exc_req = 0;
    if (!taken) begin
      repeat (20) @(negedge clk);
      chk(ln == ln0 && dcnt == d0 && !busy, "R1", "masked request started entry", 32'(ln - ln0), 0);
      return;
    end
    wait_done(seen);
    chk(seen, "R10", "done pulse", {31'b0, seen}, 1);
    chk(!busy, "R10", "busy at done", {31'b0, busy}, 0);
    chk(ln - ln0 == n, errp ? "R6" : "R4", "push count", 32'(ln - ln0), 32'(n));
    for (int k = 0; k < n && k < 8; k++) begin
      chk(log_a[(ln0 + k) % 256] == sp0 - 32'(4 * (k + 1)), "R5", "push address",
          log_a[(ln0 + k) % 256], sp0 - 32'(4 * (k + 1)));
      chk(log_d[(ln0 + k) % 256] == exp_w[k], "R4", "push word", log_d[(ln0 + k) % 256], exp_w[k]);
    end
    chk(new_sp == sp0 - 32'(4 * n), "R5", "new_sp", new_sp, sp0 - 32'(4 * n));
    chk(new_flags == (fl & ~32'h300), "R7", "new_flags", new_flags, fl & ~32'h300);
    ea = vt_base + 32'(v) * 4;
    chk(new_cs == vword(ea)[31:16], (kind >= 3) ? "R3" : "R8", "new_cs", 32'(new_cs), 32'(vword(ea)[31:16]));
    chk(new_ip == {16'h0, vword(ea)[15:0]}, "R8", "new_ip", new_ip, {16'h0, vword(ea)[15:0]});
    @(negedge clk);
    chk(!done, "R10", "done width", {31'b0, done}, 0);
  endtask

  initial begin
    logic seen;
    int ln0, d0;
    fork
      begin
        repeat (150000) @(negedge clk);
        chk(1'b0, "R10", "watchdog expired", 0, 1);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    join_none

    repeat (3) @(negedge clk);
    chk(!busy && !done && !mem_req, "R10", "reset outputs", {29'b0, busy, done, mem_req}, 0);
    chk(new_sp == 0 && new_flags == 0, "R7", "reset results", new_sp | new_flags, 0);
    rst_n = 1'b1;

    for (int i = 0; i < 10; i++) run_row(i, TBL[i]);

    // R3: request without a boundary is ignored.
    @(negedge clk);
    ln0 = ln; d0 = dcnt;
    nmi_req = 1'b1; nmi_vec = 8'h02;
    repeat (10) @(negedge clk);
    nmi_req = 1'b0;
    chk(ln == ln0 && dcnt == d0 && !busy, "R3", "no-boundary request", 32'(ln - ln0), 0);

    // R3: requests while busy start nothing and do not alter the vector.
    wait_cfg = 3; wcnt = 3;
    cur_flags = 32'h0000_0202; cur_sp = 32'h0000_4000; handler_pl = 2'd3; cur_cpl = 2'd3;
    mi_req = 1'b1; mi_vec = 8'h40; at_boundary = 1'b1;
    ln0 = ln; d0 = dcnt;
    @(negedge clk);
    mi_req = 1'b0; at_boundary = 1'b0;
    @(negedge clk);
    nmi_req = 1'b1; nmi_vec = 8'h02; at_boundary = 1'b1;
    repeat (3) @(negedge clk);
    nmi_req = 1'b0; at_boundary = 1'b0;
    wait_done(seen);
    repeat (20) @(negedge clk);
    chk(dcnt == d0 + 1, "R3", "entries while busy", 32'(dcnt - d0), 1);
    chk(ln == ln0 + 3, "R3", "pushes while busy", 32'(ln - ln0), 3);
    chk(new_cs == vword(vt_base + 32'h100)[31:16], "R3", "vector kept", 32'(new_cs),
        32'(vword(vt_base + 32'h100)[31:16]));
    chk(new_sp == 32'h0000_4000 - 12, "R9", "stalled pushes", new_sp, 32'h0000_4000 - 12);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule